// File: doc/BRIEF.md
# Serial Divisibility Checker

This block watches a stream of single bits, one offered per clock when a valid strobe is high, and treats the bits taken so far as an unsigned binary number. The first bit received is the most significant. Each accepted bit doubles the number and adds the new bit. A registered flag reports, after every clock, whether the number built so far is an exact multiple of the selected modulus.

Two moduli are supported, three and five, and a static select input chooses between them. The machine never stores the number itself. It keeps only the remainder, so its state space has as many states as the chosen modulus. The flag depends only on that stored remainder (Moore form), which means a new bit shows up on the flag one clock after it is presented.

A synchronous active-low reset returns the remainder to zero. The select input may change only while reset is asserted. A typical use is a framing or self-test monitor that has to know, on the fly, whether a serial word seen so far divides evenly.

Top module: `serial_mod_checker`

## Requirements
- R1: While reset (rst_n low) is sampled at a rising clock edge, the stored remainder becomes 0, and `divisible` reads 1 after that edge.
- R2: With `mod_sel` = 0 (modulus 3), each rising edge where `bit_vld` = 1 replaces the remainder r with (2*r + `bit_in`) mod 3. `divisible` is 1 exactly when the new remainder is 0. Example: after reset, bits 0,1,1 give flags 1,0,1.
- R3: With `mod_sel` = 1 (modulus 5), each rising edge where `bit_vld` = 1 replaces r with (2*r + `bit_in`) mod 5, and `divisible` is 1 exactly when the new remainder is 0.
- R4: A rising edge with `bit_vld` = 0 and reset released leaves the remainder and `divisible` unchanged, whatever the value of `bit_in`.
- R5: A value of zero counts as a multiple: any run of accepted 0 bits starting from reset keeps `divisible` at 1, in either mode.
- R6: `divisible` is a registered output. Between rising edges it does not follow `bit_in` or `bit_vld`; a bit's effect appears only after the edge that accepts it.
- R7: A modulus chosen while reset is asserted governs all bits accepted after reset is released. Switching modes through reset starts the new mode from remainder 0.
- R8: If reset and a valid bit are sampled at the same edge, reset wins: the bit is discarded, the remainder is 0 and `divisible` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | High when `bit_in` carries a bit to accept this cycle |
| bit_in | input | 1 | Next serial bit, most significant first |
| mod_sel | input | 1 | Modulus select: 0 = three, 1 = five; change only during reset |
| divisible | output | 1 | Registered flag, high when the accumulated value is a multiple of the modulus |

## Verification
Two events can land on the same edge: a valid bit being accepted and a synchronous reset. The bench provokes this by holding `bit_vld` high with `bit_in` = 1 during reset, once in each mode. It then requires the flag to read 1 and the next bits to be judged against a model that starts again from remainder 0. Around those collisions, long random streams with random idle gaps are compared, one vector at a time, against a reference that keeps the true value modulo the selected divisor.

// File: rtl/smc_pkg.sv
// Package: shared remainder type for the serial divisibility checker.
// Assumes every supported modulus is at most 2**SMC_REM_W.
package smc_pkg;
    localparam int SMC_REM_W = 3;
    typedef logic [SMC_REM_W-1:0] rem_t;
endpackage

// File: rtl/smc_rem_step.sv
// Module: one remainder-update step for a fixed modulus.
// Computes (2*r + b) mod MODULUS. Assumes r < MODULUS, so 2*r + b < 2*MODULUS
// and a single conditional subtraction is enough.
module smc_rem_step
    import smc_pkg::*;
#(
    parameter int MODULUS = 3
) (
    input  rem_t rem_cur,
    input  logic bit_new,
    output rem_t rem_nxt
);
    localparam int DBL_W = SMC_REM_W + 1;
    localparam logic [DBL_W-1:0] MOD_V = DBL_W'(MODULUS);

    logic [DBL_W-1:0] dbl;

    // Shift the remainder left and bring in the new bit, then fold once.
    always_comb begin
        dbl = {rem_cur, bit_new};
        if (dbl >= MOD_V) begin
            dbl = dbl - MOD_V;
        end
        rem_nxt = dbl[SMC_REM_W-1:0];
    end
endmodule

// File: rtl/smc_state_reg.sv
// Module: remainder state and registered flag.
// Loads the selected next remainder on a valid bit and holds otherwise.
// The flag register is loaded with "next remainder is zero", so it always
// equals (stored remainder == 0). Reset is synchronous and active low.
module smc_state_reg
    import smc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  rem_t rem_in,
    output rem_t rem_q,
    output logic zero_q
);
    // Remainder and flag update: reset first, then accept, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            zero_q <= 1'b1;
        end else if (load) begin
            rem_q  <= rem_in;
            zero_q <= (rem_in == '0);
        end
    end
endmodule

// File: rtl/serial_mod_checker.sv
// Module: serial MSB-first divisibility checker, modulus 3 or 5.
// Assumes mod_sel changes only while rst_n is low. One step unit is built
// per supported modulus; mod_sel picks the one that feeds the state register.
module serial_mod_checker
    import smc_pkg::*;
#(
    parameter int MOD_LO = 3,
    parameter int MOD_HI = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic mod_sel,
    output logic divisible
);
    localparam int N_MODS = 2;
    localparam int MODS [N_MODS] = '{MOD_LO, MOD_HI};

    rem_t rem_q;
    rem_t step_out [N_MODS];
    rem_t rem_sel;

    // One combinational step unit per modulus.
    for (genvar gi = 0; gi < N_MODS; gi++) begin : g_step
        smc_rem_step #(.MODULUS(MODS[gi])) u_step (
            .rem_cur (rem_q),
            .bit_new (bit_in),
            .rem_nxt (step_out[gi])
        );
    end

    // Choose the step result for the configured modulus.
    always_comb begin
        rem_sel = mod_sel ? step_out[1] : step_out[0];
    end

    smc_state_reg u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bit_vld),
        .rem_in (rem_sel),
        .rem_q  (rem_q),
        .zero_q (divisible)
    );
endmodule

// File: rtl/smc_chk.sv
// Checker: temporal properties of serial_mod_checker, bound to every instance.
module smc_chk
    import smc_pkg::*;
#(
    parameter int MOD_LO = 3,
    parameter int MOD_HI = 5
) (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic mod_sel,
    input logic divisible,
    input rem_t rem_q
);
    // R1
    reset_flag_chk: assert property (@(posedge clk) !rst_n |=> (divisible && rem_q == '0));

    // R8
    reset_wins_chk: assert property (@(posedge clk) (!rst_n && bit_vld) |=> (rem_q == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && $past(rst_n)) |=> ($stable(rem_q) && $stable(divisible)));

    // R2
    rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rem_q) < (mod_sel ? MOD_HI : MOD_LO)));

    // R6
    flag_moore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        divisible == (rem_q == '0));
endmodule

bind serial_mod_checker smc_chk #(.MOD_LO(MOD_LO), .MOD_HI(MOD_HI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .mod_sel   (mod_sel),
    .divisible (divisible),
    .rem_q     (rem_q)
);

// File: tb/serial_mod_checker_tb.sv
`timescale 1ns/1ps
module serial_mod_checker_tb;
    typedef struct {
        logic  flag;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic mod_sel = 1'b0;
    logic divisible;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   ref_rem = 0;
    int   modn = 3;
    logic last_exp = 1'b1;

    always #2.5 clk = ~clk;

    serial_mod_checker u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .mod_sel   (mod_sel),
        .divisible (divisible)
    );

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: divisible=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Driver: reset cycle, possibly colliding with a valid bit (R1, R7, R8).
    task automatic apply_reset(logic sel, logic vld, logic b, string tag);
        @(negedge clk);
        rst_n = 1'b0; mod_sel = sel; bit_vld = vld; bit_in = b;
        @(posedge clk);
        #1;
        ref_rem  = 0;
        modn     = sel ? 5 : 3;
        last_exp = 1'b1;
        sbq.push_back('{1'b1, tag});
    endtask

    // Driver: one cycle of stimulus; model update and scoreboard push.
    task automatic send(logic vld, logic b, string tag);
        @(negedge clk);
        rst_n = 1'b1; bit_vld = vld; bit_in = b;
        #1;
        check("R6 flag moved before edge", divisible, last_exp);
        if (vld) ref_rem = (ref_rem * 2 + int'(b)) % modn;
        last_exp = (ref_rem == 0);
        @(posedge clk);
        #1;
        sbq.push_back('{last_exp, tag});
    endtask

    // Monitor: pop one expected item per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(e.tag, divisible, e.flag);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: plain reset in mode 3
        apply_reset(1'b0, 1'b0, 1'b0, "R1 reset flag");
        // R2, R5: 0,1,1 -> 1,0,1
        send(1'b1, 1'b0, "R5 zero value");
        send(1'b1, 1'b1, "R2 value 1");
        send(1'b1, 1'b1, "R2 value 3");
        // R4: idle cycles with bit_in wiggling
        send(1'b1, 1'b1, "R2 value 7");
        for (int i = 0; i < 4; i++) send(1'b0, i[0], "R4 idle hold");
        // R2: random stream with gaps
        for (int i = 0; i < 96; i++) begin
            send(($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), "R2 random mod3");
        end
        // R7, R8: switch to mode 5 with a colliding valid bit
        apply_reset(1'b1, 1'b1, 1'b1, "R8 reset beats bit");
        for (int i = 0; i < 5; i++) send(1'b1, 1'b0, "R5 zeros mod5");
        send(1'b1, 1'b1, "R7 value 1 mod5");
        send(1'b1, 1'b0, "R7 value 2 mod5");
        send(1'b1, 1'b1, "R3 value 5 mod5");
        for (int i = 0; i < 3; i++) send(1'b0, 1'b1, "R4 idle hold mod5");
        for (int i = 0; i < 96; i++) begin
            send(($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), "R3 random mod5");
        end
        // R8 back to mode 3, then 1,1 -> value 3
        apply_reset(1'b0, 1'b1, 1'b1, "R8 reset beats bit mod3");
        send(1'b1, 1'b1, "R7 value 1 mod3");
        send(1'b1, 1'b1, "R7 value 3 mod3");
        send(1'b0, 1'b0, "R4 final idle");
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule